// File: doc/BRIEF.md
# Lane-masked compare and select unit

This unit compares two operand vectors lane by lane as signed integers and turns each lane's result into a condition. The lane width can be 8, 16, 32 or 64 bits. The condition is reported in two forms: a full-width vector that holds all-ones or all-zeros in every lane, and a packed mask with one bit per lane. The unit then blends a computed vector with a previous-value vector under that condition. The predicate and lane width are chosen per operation.

There are two operating formats. The legacy format knows only the equal and greater-than predicates. It ignores the lane enables and blends with an and/andnot/or sequence. The packed-mask format accepts all six predicates and gates each lane's compare with a per-lane enable bit, which gives the logical AND of two conditions. It then merges, keeping the previous value in lanes whose condition is 0. Alternatively it zero-fills those lanes.

An operation starts with a one-cycle `start` pulse in the idle state. A four-state sequencer moves through the states Idle, Compare, Blend and Done:
- Idle to Compare is the Launch transition. It captures every input.
- Compare to Blend is the Evaluate transition. It registers the per-lane conditions.
- Blend to Done is the Commit transition. It registers all outputs.
- Done to Idle is the Retire transition.

`done` is high for the single cycle spent in Done. The outputs then hold until the next Commit.

Top module: `lmcs_unit`

## Requirements
- R1: After reset, `done`, `illegal`, `cond_bits`, `cond_vec` and `blend_out` are all zero.
- R2: A `start` sampled high in the idle state captures every input. `done` rises exactly three rising edges later and stays high for one cycle. Any `start` or input change while the unit is not idle has no effect on that operation's results.
- R3: Lanes are compared as signed two's-complement integers. `width_sel` encodes the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Lane l occupies bits [l*W +: W].
- R4: With `mask_fmt`=0 (legacy), `pred_sel` must be 0 (equal) or 4 (greater-than). Any other code sets `illegal` and yields all-zero conditions. `cond_vec` holds all-ones in a lane whose condition is true and all-zeros otherwise.
- R5: With `mask_fmt`=1, the `pred_sel` codes are 0 = equal, 1 = not-equal, 2 = less-than, 3 = less-or-equal, 4 = greater-than and 5 = greater-or-equal, all comparing A against B. Codes 6 and 7 set `illegal` and yield all-zero conditions.
- R6: `cond_bits` bit l carries lane l's condition. Bits at or above the lane count (`VEC_W`/W) are zero.
- R7: In legacy format `blend_out` = (`cond_vec` AND `calc_vec`) OR ((NOT `cond_vec`) AND `prev_vec`). `lane_en` and `zero_fill` have no effect.
- R8: In packed-mask format with `zero_fill`=0, a lane whose condition is 1 takes `calc_vec` and a lane whose condition is 0 takes `prev_vec`.
- R9: In packed-mask format with `zero_fill`=1, a lane whose condition is 0 outputs zero.
- R10: In packed-mask format the condition of lane l is the predicate result AND `lane_en`[l]. Enable bits at or above the lane count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, honoured only when idle |
| opnd_a | input | VEC_W | First compare operand |
| opnd_b | input | VEC_W | Second compare operand |
| calc_vec | input | VEC_W | Computed vector selected where the condition is true |
| prev_vec | input | VEC_W | Previous-value vector used where the condition is false |
| pred_sel | input | 3 | Predicate code |
| width_sel | input | 2 | Lane width code |
| lane_en | input | VEC_W/8 | Per-lane compare enables (packed-mask format) |
| mask_fmt | input | 1 | 0 = legacy format, 1 = packed-mask format |
| zero_fill | input | 1 | Packed-mask format: 1 zero-fills false lanes |
| done | output | 1 | One-cycle result-valid pulse |
| illegal | output | 1 | Predicate not allowed in the chosen format |
| cond_bits | output | VEC_W/8 | One condition bit per lane |
| cond_vec | output | VEC_W | Condition expanded to all-ones/all-zeros lanes |
| blend_out | output | VEC_W | Blended result |

## Verification
The properties rely on three assumptions. First, `width_sel` and `mask_fmt` captured at Launch describe the outputs seen while `done` is high. Second, reset is asserted from time zero. Third, `start` is a request in the idle state rather than a level that must be held. The bench drives every input at falling edges and only pulses `start` from idle, except for one deliberate case. In that case `start` stays high into the Compare state while the operands and predicate change, which shows that only the captured values count. The sweep covers every lane width, predicate code, format and fill mode over vectors that force equal, extreme-signed and partly equal lanes. The enable bits it uses include ones above the lane count.

// File: rtl/lmcs_pkg.sv
package lmcs_pkg;

    localparam int unsigned MIN_LANE   = 8;
    localparam int unsigned NUM_WIDTHS = 4;

    typedef enum logic [2:0] {
        P_EQ   = 3'd0,
        P_NE   = 3'd1,
        P_LT   = 3'd2,
        P_LE   = 3'd3,
        P_GT   = 3'd4,
        P_GE   = 3'd5,
        P_RSV6 = 3'd6,
        P_RSV7 = 3'd7
    } pred_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMP   = 2'd1,
        ST_BLEND = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    // Evaluate one predicate from the equal and signed-less-than flags.
    function automatic logic pred_hit(input logic eq, input logic lt, input pred_e p);
        logic r;
        unique case (p)
            P_EQ:    r = eq;
            P_NE:    r = !eq;
            P_LT:    r = lt;
            P_LE:    r = lt | eq;
            P_GT:    r = !(lt | eq);
            P_GE:    r = !lt;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // Legacy format knows only equal and greater-than.
    function automatic logic pred_legal(input pred_e p, input logic packed_fmt);
        logic r;
        if (packed_fmt) r = (p != P_RSV6) && (p != P_RSV7);
        else            r = (p == P_EQ) || (p == P_GT);
        return r;
    endfunction

endpackage

// File: rtl/lmcs_cmp_bank.sv
module lmcs_cmp_bank
    import lmcs_pkg::*;
#(
    parameter int unsigned VEC_W  = 64,
    parameter int unsigned LANE_W = 8
) (
    input  logic [VEC_W-1:0]        opnd_a,
    input  logic [VEC_W-1:0]        opnd_b,
    input  pred_e                   pred,
    output logic [VEC_W/LANE_W-1:0] hit
);
    localparam int unsigned NL = VEC_W / LANE_W;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic signed [LANE_W-1:0] la;
        logic signed [LANE_W-1:0] lb;
        assign la     = opnd_a[l*LANE_W +: LANE_W];
        assign lb     = opnd_b[l*LANE_W +: LANE_W];
        assign hit[l] = pred_hit(la == lb, la < lb, pred);
    end

endmodule

// File: rtl/lmcs_expand.sv
module lmcs_expand
    import lmcs_pkg::*;
#(
    parameter int unsigned VEC_W = 64
) (
    input  logic [VEC_W/MIN_LANE-1:0] bits,
    input  logic [1:0]                width_code,
    output logic [VEC_W-1:0]          vec
);
    localparam int unsigned MAXL = VEC_W / MIN_LANE;
    localparam int unsigned IW   = $clog2(MAXL);

    // Byte i belongs to lane (i >> width_code).
    for (genvar i = 0; i < MAXL; i++) begin : g_byte
        localparam logic [IW-1:0] BYTE_IDX = IW'(i);
        assign vec[i*MIN_LANE +: MIN_LANE] = {MIN_LANE{bits[BYTE_IDX >> width_code]}};
    end

endmodule

// File: rtl/lmcs_blend.sv
module lmcs_blend #(
    parameter int unsigned VEC_W = 64
) (
    input  logic [VEC_W-1:0] sel_vec,
    input  logic [VEC_W-1:0] calc_vec,
    input  logic [VEC_W-1:0] prev_vec,
    input  logic             packed_fmt,
    input  logic             zero_fill,
    output logic [VEC_W-1:0] out_vec
);
    // The inverted operand comes first, as in the classic andnot step.
    function automatic logic [VEC_W-1:0] and_not(input logic [VEC_W-1:0] x,
                                                 input logic [VEC_W-1:0] y);
        return ~x & y;
    endfunction

    logic [VEC_W-1:0] fallback;
    logic [VEC_W-1:0] take_part;
    logic [VEC_W-1:0] keep_part;

    always_comb begin
        fallback  = (packed_fmt && zero_fill) ? '0 : prev_vec;
        take_part = sel_vec & calc_vec;
        keep_part = and_not(sel_vec, fallback);
        out_vec   = take_part | keep_part;
    end

endmodule

// File: rtl/lmcs_unit.sv
module lmcs_unit
    import lmcs_pkg::*;
#(
    parameter int unsigned VEC_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [VEC_W-1:0]          opnd_a,
    input  logic [VEC_W-1:0]          opnd_b,
    input  logic [VEC_W-1:0]          calc_vec,
    input  logic [VEC_W-1:0]          prev_vec,
    input  logic [2:0]                pred_sel,
    input  logic [1:0]                width_sel,
    input  logic [VEC_W/8-1:0]        lane_en,
    input  logic                      mask_fmt,
    input  logic                      zero_fill,
    output logic                      done,
    output logic                      illegal,
    output logic [VEC_W/8-1:0]        cond_bits,
    output logic [VEC_W-1:0]          cond_vec,
    output logic [VEC_W-1:0]          blend_out
);
    localparam int unsigned MAXL = VEC_W / MIN_LANE;
    localparam logic [MAXL:0] ONE_EXT = (MAXL+1)'(1);

    state_e state, nxt_state;

    // Captured operation
    logic [VEC_W-1:0] a_q, b_q, calc_q, prev_q;
    pred_e            pred_q;
    logic [1:0]       lw_q;
    logic [MAXL-1:0]  en_q;
    logic             fmt_q, zfill_q;

    // Evaluated conditions
    logic [MAXL-1:0]  cond_q;
    logic             bad_q;

    // Compare banks, one per lane width
    logic [NUM_WIDTHS-1:0][MAXL-1:0] hit_all;

    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_bank
        localparam int unsigned LW = MIN_LANE << k;
        localparam int unsigned NL = VEC_W / LW;
        logic [NL-1:0] hit_k;
        lmcs_cmp_bank #(.VEC_W(VEC_W), .LANE_W(LW)) bank_i (
            .opnd_a (a_q),
            .opnd_b (b_q),
            .pred   (pred_q),
            .hit    (hit_k)
        );
        assign hit_all[k] = MAXL'(hit_k);
    end

    // Lanes that exist at the captured width
    logic [MAXL:0]   lim_ext;
    logic [MAXL-1:0] lane_ok;
    logic [MAXL-1:0] gate;
    logic [MAXL-1:0] cond_d;
    logic            legal_d;

    always_comb begin
        lim_ext = ONE_EXT << (MAXL >> lw_q);
        lane_ok = MAXL'(lim_ext - ONE_EXT);
        gate    = fmt_q ? en_q : '1;
        legal_d = pred_legal(pred_q, fmt_q);
        cond_d  = legal_d ? (hit_all[lw_q] & gate & lane_ok) : '0;
    end

    // Expansion and blend of the registered conditions
    logic [VEC_W-1:0] vec_d;
    logic [VEC_W-1:0] blend_d;

    lmcs_expand #(.VEC_W(VEC_W)) expand_i (
        .bits       (cond_q),
        .width_code (lw_q),
        .vec        (vec_d)
    );

    lmcs_blend #(.VEC_W(VEC_W)) blend_i (
        .sel_vec    (vec_d),
        .calc_vec   (calc_q),
        .prev_vec   (prev_q),
        .packed_fmt (fmt_q),
        .zero_fill  (zfill_q),
        .out_vec    (blend_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Transitions: Launch, Evaluate, Commit, Retire
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:  if (start) nxt_state = ST_CMP;
            ST_CMP:   nxt_state = ST_BLEND;
            ST_BLEND: nxt_state = ST_DONE;
            ST_DONE:  nxt_state = ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // Datapath registers advanced by the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q       <= '0;
            b_q       <= '0;
            calc_q    <= '0;
            prev_q    <= '0;
            pred_q    <= P_EQ;
            lw_q      <= '0;
            en_q      <= '0;
            fmt_q     <= 1'b0;
            zfill_q   <= 1'b0;
            cond_q    <= '0;
            bad_q     <= 1'b0;
            illegal   <= 1'b0;
            cond_bits <= '0;
            cond_vec  <= '0;
            blend_out <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_q     <= opnd_a;
                        b_q     <= opnd_b;
                        calc_q  <= calc_vec;
                        prev_q  <= prev_vec;
                        pred_q  <= pred_e'(pred_sel);
                        lw_q    <= width_sel;
                        en_q    <= lane_en;
                        fmt_q   <= mask_fmt;
                        zfill_q <= zero_fill;
                    end
                end
                ST_CMP: begin
                    cond_q <= cond_d;
                    bad_q  <= !legal_d;
                end
                ST_BLEND: begin
                    cond_bits <= cond_q;
                    cond_vec  <= vec_d;
                    blend_out <= blend_d;
                    illegal   <= bad_q;
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb done = (state == ST_DONE);

endmodule

// File: rtl/lmcs_chk.sv
module lmcs_chk #(
    parameter int unsigned VEC_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               illegal,
    input logic [VEC_W/8-1:0] cond_bits,
    input logic [VEC_W-1:0]   cond_vec,
    input logic [VEC_W-1:0]   blend_out,
    input logic [1:0]         lw_q,
    input logic [VEC_W/8-1:0] en_q,
    input logic               fmt_q,
    input logic               zfill_q,
    input logic [VEC_W-1:0]   calc_q,
    input logic [VEC_W-1:0]   prev_q
);
    localparam int unsigned MAXL = VEC_W / 8;
    localparam logic [MAXL:0] ONE_EXT = (MAXL+1)'(1);

    logic [MAXL:0]   lim_ext;
    logic [MAXL-1:0] present;
    always_comb begin
        lim_ext = ONE_EXT << (MAXL >> lw_q);
        present = MAXL'(lim_ext - ONE_EXT);
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_illegal_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (cond_bits == '0 && cond_vec == '0));

    assert_upper_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((cond_bits & ~present) == '0));

    assert_legacy_blend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fmt_q) |-> (blend_out == ((cond_vec & calc_q) | (~cond_vec & prev_q))));

    assert_merge_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fmt_q && !zfill_q) |-> ((blend_out & ~cond_vec) == (prev_q & ~cond_vec)));

    assert_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fmt_q && zfill_q) |-> ((blend_out & ~cond_vec) == '0));

    assert_enable_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fmt_q) |-> ((cond_bits & ~en_q) == '0));

endmodule

bind lmcs_unit lmcs_chk #(.VEC_W(VEC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .illegal   (illegal),
    .cond_bits (cond_bits),
    .cond_vec  (cond_vec),
    .blend_out (blend_out),
    .lw_q      (lw_q),
    .en_q      (en_q),
    .fmt_q     (fmt_q),
    .zfill_q   (zfill_q),
    .calc_q    (calc_q),
    .prev_q    (prev_q)
);

// File: tb/lmcs_unit_tb_top.sv
module lmcs_unit_tb_top;
    localparam int unsigned VW = 64;
    localparam int unsigned ML = VW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [VW-1:0] opnd_a = '0, opnd_b = '0, calc_vec = '0, prev_vec = '0;
    logic [2:0]    pred_sel = '0;
    logic [1:0]    width_sel = '0;
    logic [ML-1:0] lane_en = '0;
    logic          mask_fmt = 1'b0, zero_fill = 1'b0;
    logic          done, illegal;
    logic [ML-1:0] cond_bits;
    logic [VW-1:0] cond_vec, blend_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lmcs_unit #(.VEC_W(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .calc_vec(calc_vec), .prev_vec(prev_vec),
        .pred_sel(pred_sel), .width_sel(width_sel), .lane_en(lane_en),
        .mask_fmt(mask_fmt), .zero_fill(zero_fill),
        .done(done), .illegal(illegal), .cond_bits(cond_bits),
        .cond_vec(cond_vec), .blend_out(blend_out)
    );

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] xs(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    // Reference computed from the requirements
    task automatic ref_model(input logic [VW-1:0] a, b, c, s, input logic [2:0] p,
                             input logic [1:0] lw, input logic [ML-1:0] k,
                             input logic mm, zm,
                             output logic [ML-1:0] e_bits, output logic [VW-1:0] e_vec,
                             output logic [VW-1:0] e_res, output logic e_bad);
        int w, nl;
        logic legal;
        w  = 8 << lw;
        nl = ML >> lw;
        legal = (p < 3'd6) && (mm || p == 3'd0 || p == 3'd4);
        e_bad  = !legal;
        e_bits = '0;
        for (int l = 0; l < nl; l++) begin
            logic [63:0] ta, tb;
            longint sa, sb;
            logic h;
            ta = a >> (l * w);
            tb = b >> (l * w);
            ta = ta << (64 - w);
            tb = tb << (64 - w);
            sa = $signed(ta) >>> (64 - w);
            sb = $signed(tb) >>> (64 - w);
            case (p)
                3'd0: h = (sa == sb);
                3'd1: h = (sa != sb);
                3'd2: h = (sa < sb);
                3'd3: h = (sa <= sb);
                3'd4: h = (sa > sb);
                3'd5: h = (sa >= sb);
                default: h = 1'b0;
            endcase
            e_bits[l] = legal && h && (mm ? k[l] : 1'b1);
        end
        for (int i = 0; i < ML; i++) e_vec[i*8 +: 8] = {8{e_bits[i >> lw]}};
        if (!mm) e_res = (e_vec & c) | (~e_vec & s);
        else begin
            for (int i = 0; i < ML; i++)
                e_res[i*8 +: 8] = e_vec[i*8] ? c[i*8 +: 8] : (zm ? 8'h00 : s[i*8 +: 8]);
        end
    endtask

    task automatic do_op(input logic [VW-1:0] a, b, c, s, input logic [2:0] p,
                         input logic [1:0] lw, input logic [ML-1:0] k,
                         input logic mm, zm, input bit hold_start);
        logic [ML-1:0] e_bits;
        logic [VW-1:0] e_vec, e_res;
        logic e_bad;
        string rq;
        ref_model(a, b, c, s, p, lw, k, mm, zm, e_bits, e_vec, e_res, e_bad);
        @(negedge clk);
        opnd_a = a; opnd_b = b; calc_vec = c; prev_vec = s;
        pred_sel = p; width_sel = lw; lane_en = k; mask_fmt = mm; zero_fill = zm;
        start = 1'b1;
        @(negedge clk);
        if (hold_start) begin
            opnd_a = ~a; opnd_b = a; pred_sel = p ^ 3'd1; lane_en = ~k;
        end else start = 1'b0;
        chk(done == 1'b0, "R2 done early", VW'(done), 0);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R2 done early", VW'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R2 done missing", VW'(done), 1);
        chk(illegal == e_bad, mm ? "R5 illegal" : "R4 illegal", VW'(illegal), VW'(e_bad));
        chk(cond_bits == e_bits, mm ? "R10 R6 R3 cond_bits" : "R6 R3 cond_bits",
            VW'(cond_bits), VW'(e_bits));
        chk(cond_vec == e_vec, "R4 R3 cond_vec", cond_vec, e_vec);
        rq = !mm ? "R7 blend" : (zm ? "R9 zero blend" : "R8 merge blend");
        chk(blend_out == e_res, rq, blend_out, e_res);
        @(negedge clk);
        chk(done == 1'b0, "R2 done pulse width", VW'(done), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] seed;
        seed = 64'h1234_5678_9ABC_DEF1;
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is held
        chk(done == 1'b0 && illegal == 1'b0, "R1 flags", {done, illegal}, 0);
        chk(cond_bits == '0, "R1 cond_bits", VW'(cond_bits), 0);
        chk(cond_vec == '0 && blend_out == '0, "R1 vectors", cond_vec | blend_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 idle after release", VW'(done), 0);

        // R2: start held into Compare with changed inputs
        do_op(64'h0102_0304_8000_7FFF, 64'h0102_0300_7FFF_8000, 64'hAAAA_AAAA_AAAA_AAAA,
              64'h5555_5555_5555_5555, 3'd0, 2'd1, 8'hFF, 1'b1, 1'b0, 1'b1);

        for (int lw = 0; lw < 4; lw++)
            for (int p = 0; p < 8; p++)
                for (int mz = 0; mz < 3; mz++)
                    for (int v = 0; v < 12; v++) begin
                        logic [63:0] a, b, c, s, r, pat;
                        logic [ML-1:0] k;
                        seed = xs(seed); a = seed;
                        seed = xs(seed); r = seed;
                        seed = xs(seed); c = seed;
                        seed = xs(seed); s = seed;
                        seed = xs(seed); k = seed[ML-1:0];
                        for (int i = 0; i < ML; i++) pat[i*8 +: 8] = {8{seed[20+i]}};
                        case (v)
                            0: b = a;
                            1: begin a = 64'h807F_0080_FF01_7F80; b = 64'h7F80_8000_01FF_807F; end
                            2: begin a = 64'h0; b = 64'hFFFF_FFFF_FFFF_FFFF; end
                            3: begin a = 64'h8000_0000_0000_0000; b = 64'h7FFF_FFFF_FFFF_FFFF; end
                            default: b = (r & pat) | (a & ~pat);
                        endcase
                        // mz: 0 legacy (random enable/fill must be ignored), 1 merge, 2 zero
                        do_op(a, b, c, s, 3'(p), 2'(lw), k, mz != 0,
                              (mz == 2) || (mz == 0 && seed[40]), 1'b0);
                    end
        summary();
        $finish;
    end

endmodule